// File: doc/BRIEF.md
# Dual-Address Two-Wire Memory and Register Slave

This block is a two-wire serial bus slave that answers to two distinct 7-bit device addresses on one bus. One address opens a byte-wide memory array. The other opens a small bank of 21 control registers. To a bus master the two look like two independent slaves. The memory is always addressed with two address bytes, high byte first, whatever its configured depth. Writes land in the array in the same clock cycle the data byte completes, so the master never has to wait or poll. Two bits of register 11 choose a protected region at the bottom of the array. A data byte aimed at a protected location is dropped, and the slave answers it with a not-acknowledge.

The controller is one state machine. From reset it sits in `S_IDLE`. A START moves it to `S_DEV`, which collects the address byte. A matching address moves to `S_DEV_ACK`. Any other address falls back to `S_IDLE`. After the acknowledge, a read goes to `S_RD`. A memory write goes to `S_AHI`, then `S_AHI_ACK`, then `S_ALO`. A register write goes straight to `S_ALO`. `S_ALO` leads to `S_ALO_ACK` and then to `S_WR`, which alternates with `S_WR_ACK` for each data byte. `S_RD` alternates with `S_RD_ACK`. A master acknowledge goes back to `S_RD`, and a master not-acknowledge goes to `S_IDLE`. From any state, a START returns to `S_DEV` and a STOP returns to `S_IDLE`.

The memory pointer and the register pointer are separate. A current-address memory read therefore continues from the last memory byte even when register traffic came in between.

Top module: `dual_id_twi_slave`

## Requirements
- R1: An address byte whose upper seven bits equal MEM_ID (default 0x50) or REG_ID (default 0x68) is acknowledged. Any other address is not acknowledged, and the slave stays silent until the next START.
- R2: A memory write sends a high address byte, a low address byte, then data. Address bits above the array width are ignored, so 0x0210 aliases 0x0010 in a 512-byte array. A later random read returns the written byte.
- R3: During sequential writes or reads the memory pointer advances by one after every byte and wraps from DEPTH-1 to 0.
- R4: Register-bank transactions leave the memory pointer unchanged. A current-address memory read (START, MEM_ID with read bit, data) returns the byte after the last memory byte accessed.
- R5: With register 11 bits [1:0] = 00, every memory location accepts and acknowledges writes.
- R6: With register 11 bits [1:0] = 01, addresses below DEPTH/4 are protected. A data byte sent to them is neither stored nor acknowledged. Addresses from DEPTH/4 upward accept writes.
- R7: With 10 the protected range is below DEPTH/2. With 11 the whole array is protected.
- R8: The register bank uses a single address byte. Registers 0 to 20 hold written values, and a read returns them, with the register pointer auto-incrementing.
- R9: A register address of 21 or above reads as 0x00. Writes to it are ignored but still acknowledged.
- R10: A STOP at any point returns the slave to idle, and a byte cut short by it is not written. A START at any point restarts the address phase. Once a STOP has been seen, no byte is acknowledged until a new START.
- R11: After reset the slave does not drive SDA, and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND bus value) |
| sda_oe | output | 1 | When high, the pad pulls SDA low |

## Verification
The bench first writes one byte to each side of every protection boundary (DEPTH/4 - 1 against DEPTH/4, and DEPTH/2 - 1 against DEPTH/2) and then reads them back. An off-by-one compare would either protect a byte that should accept writes or store a byte that should be rejected. It also writes across the top of the array, where a pointer that failed to wrap would send the second byte to the wrong place. A register read is placed between two memory reads: a design sharing one pointer between the two address spaces would return the wrong byte on the current-address read. A STOP is sent in the middle of a data byte, and a stray address byte is sent without a START. A design that still stored the partial byte, or that stayed armed after STOP, would show a changed memory byte or an acknowledge.

// File: rtl/dual_id_pkg.sv
package dual_id_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } slv_state_t;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    // [SYNC-1] is the synchronised value, [SYNC] the value one cycle older
    logic [SYNC:0] scl_sh;
    logic [SYNC:0] sda_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC-1:0], sda_i};
        end
    end

    logic scl_c, scl_p, sda_p;
    assign scl_c     = scl_sh[SYNC-1];
    assign scl_p     = scl_sh[SYNC];
    assign sda_s     = sda_sh[SYNC-1];
    assign sda_p     = sda_sh[SYNC];
    assign scl_rise  = scl_c & ~scl_p;
    assign scl_fall  = ~scl_c & scl_p;
    assign start_det = scl_c & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_c & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/dual_id_mem.sv
module dual_id_mem #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dual_id_regs.sv
module dual_id_regs
    import dual_id_pkg::*;
#(
    parameter int NREG   = 21,
    parameter int WP_IDX = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output prot_t      wp
);
    localparam logic [7:0] LIMIT = 8'(NREG);

    logic [NREG-1:0][7:0] regs;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       regs[g] <= '0;
            else if (we && addr == 8'(g))     regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (addr == 8'(k)) rdata = regs[k];
        end
    end

    assign wp = prot_t'(regs[WP_IDX][1:0]);

    // Out-of-range writes must leave the bank untouched
    assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr >= LIMIT) |=> $stable(regs));

endmodule

// File: rtl/dual_id_twi_slave.sv
module dual_id_twi_slave
    import dual_id_pkg::*;
#(
    parameter int         DEPTH  = 512,
    parameter int         NREG   = 21,
    parameter logic [6:0] MEM_ID = 7'h50,
    parameter logic [6:0] REG_ID = 7'h68,
    parameter int         SYNC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int            AW    = $clog2(DEPTH);
    localparam logic [AW-1:0] Q_LIM = AW'(DEPTH / 4);
    localparam logic [AW-1:0] H_LIM = AW'(DEPTH / 2);

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;

    twi_line_sync #(.SYNC(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    slv_state_t    state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg, tx, addr_hi, reg_ptr;
    logic [AW-1:0] mem_ptr;
    logic          ack_q, sel_mem, rw_q, mack_q;

    logic [7:0] mem_rdata, reg_rdata, rd_byte;
    logic       mem_we, reg_we, prot, byte_done, rx_state;
    logic [15:0] addr16;
    prot_t      wp;

    dual_id_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_ptr), .wdata(shreg),
        .raddr(mem_ptr), .rdata(mem_rdata)
    );

    dual_id_regs #(.NREG(NREG), .WP_IDX(11)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_ptr),
        .wdata(shreg), .rdata(reg_rdata), .wp(wp)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign rx_state  = (state == S_DEV) || (state == S_AHI) ||
                       (state == S_ALO) || (state == S_WR);
    assign addr16    = {addr_hi, shreg};
    assign rd_byte   = sel_mem ? mem_rdata : reg_rdata;

    always_comb begin
        unique case (wp)
            PROT_NONE:    prot = 1'b0;
            PROT_QUARTER: prot = (mem_ptr < Q_LIM);
            PROT_HALF:    prot = (mem_ptr < H_LIM);
            PROT_ALL:     prot = 1'b1;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            addr_hi <= '0;
            reg_ptr <= '0;
            mem_ptr <= '0;
            ack_q   <= 1'b0;
            sel_mem <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (start_det) begin
            state  <= S_DEV;
            bitcnt <= '0;
        end else if (stop_det) begin
            state  <= S_IDLE;
            bitcnt <= '0;
        end else begin
            if (scl_rise && (rx_state || state == S_RD)) begin
                bitcnt <= bitcnt + 4'd1;
                if (rx_state) shreg <= {shreg[6:0], sda_s};
            end
            unique case (state)
                S_IDLE: ;
                S_DEV: if (byte_done) begin
                    bitcnt <= '0;
                    rw_q   <= shreg[0];
                    if (shreg[7:1] == MEM_ID) begin
                        sel_mem <= 1'b1;
                        state   <= S_DEV_ACK;
                    end else if (shreg[7:1] == REG_ID) begin
                        sel_mem <= 1'b0;
                        state   <= S_DEV_ACK;
                    end else begin
                        state   <= S_IDLE;
                    end
                end
                S_DEV_ACK: if (scl_fall) begin
                    if (rw_q) begin
                        tx    <= rd_byte;
                        state <= S_RD;
                        if (sel_mem) mem_ptr <= mem_ptr + 1'b1;
                        else         reg_ptr <= reg_ptr + 8'd1;
                    end else begin
                        state <= sel_mem ? S_AHI : S_ALO;
                    end
                end
                S_AHI: if (byte_done) begin
                    bitcnt  <= '0;
                    addr_hi <= shreg;
                    state   <= S_AHI_ACK;
                end
                S_AHI_ACK: if (scl_fall) state <= S_ALO;
                S_ALO: if (byte_done) begin
                    bitcnt <= '0;
                    if (sel_mem) mem_ptr <= addr16[AW-1:0];
                    else         reg_ptr <= shreg;
                    state  <= S_ALO_ACK;
                end
                S_ALO_ACK: if (scl_fall) state <= S_WR;
                S_WR: if (byte_done) begin
                    bitcnt <= '0;
                    ack_q  <= !(sel_mem && prot);
                    if (sel_mem) mem_ptr <= mem_ptr + 1'b1;
                    else         reg_ptr <= reg_ptr + 8'd1;
                    state  <= S_WR_ACK;
                end
                S_WR_ACK: if (scl_fall) state <= S_WR;
                S_RD: if (scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        state  <= S_RD_ACK;
                    end else begin
                        tx <= {tx[6:0], 1'b0};
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) mack_q <= !sda_s;
                    if (scl_fall) begin
                        if (mack_q) begin
                            tx    <= rd_byte;
                            state <= S_RD;
                            if (sel_mem) mem_ptr <= mem_ptr + 1'b1;
                            else         reg_ptr <= reg_ptr + 8'd1;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we = (state == S_WR) && byte_done && sel_mem && !prot && !start_det && !stop_det;
        reg_we = (state == S_WR) && byte_done && !sel_mem && !start_det && !stop_det;
        unique case (state)
            S_DEV_ACK, S_AHI_ACK, S_ALO_ACK: sda_oe = 1'b1;
            S_WR_ACK:                        sda_oe = ack_q;
            S_RD:                            sda_oe = !tx[7];
            default:                         sda_oe = 1'b0;
        endcase
    end

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == S_IDLE);
    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == S_DEV);
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_mem |=> $stable(mem_ptr));
    assert_full_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wp != PROT_ALL);
    assert_quarter_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp == PROT_QUARTER) |-> mem_ptr >= Q_LIM);

endmodule

// File: tb/dual_id_twi_slave_tb.sv
module dual_id_twi_slave_tb_top;

    localparam int         H      = 8;
    localparam logic [6:0] MEM_ID = 7'h50;
    localparam logic [6:0] REG_ID = 7'h68;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dual_id_twi_slave #(.DEPTH(512), .NREG(21), .MEM_ID(MEM_ID), .REG_ID(REG_ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H / 2);
        b = sda_bus;  wt(H / 2);
        scl_m = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(input logic more, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!more);
    endtask

    task automatic mem_open_wr(input logic [15:0] a, input string tag);
        logic ack;
        i2c_start();
        send_byte({MEM_ID, 1'b0}, ack); chk({tag, " dev ack"}, ack, 1);
        send_byte(a[15:8], ack);        chk({tag, " addr hi ack"}, ack, 1);
        send_byte(a[7:0], ack);         chk({tag, " addr lo ack"}, ack, 1);
    endtask

    task automatic mem_open_rd(input logic [15:0] a, input string tag);
        logic ack;
        mem_open_wr(a, tag);
        i2c_start();
        send_byte({MEM_ID, 1'b1}, ack); chk({tag, " rd dev ack"}, ack, 1);
    endtask

    task automatic mem_wr1(input logic [15:0] a, input logic [7:0] d, output logic ack);
        mem_open_wr(a, "wr");
        send_byte(d, ack);
        i2c_stop();
    endtask

    task automatic mem_rd1(input logic [15:0] a, output logic [7:0] d);
        mem_open_rd(a, "rd");
        recv_byte(1'b0, d);
        i2c_stop();
    endtask

    task automatic reg_wr1(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        i2c_start();
        send_byte({REG_ID, 1'b0}, ack); chk("R1 reg dev ack", ack, 1);
        send_byte(a, ack);              chk("R8 reg addr ack", ack, 1);
        send_byte(d, ack);              chk("R8 reg data ack", ack, 1);
        i2c_stop();
    endtask

    task automatic reg_rd1(input logic [7:0] a, output logic [7:0] d);
        logic ack;
        i2c_start();
        send_byte({REG_ID, 1'b0}, ack);
        send_byte(a, ack);
        i2c_start();
        send_byte({REG_ID, 1'b1}, ack); chk("R1 reg rd dev ack", ack, 1);
        recv_byte(1'b0, d);
        i2c_stop();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] d;
        chk("R11 sda released after reset", sda_oe, 0);
        reg_rd1(8'd11, d);
        chk("R11 reg 11 zero after reset", d, 8'h00);
    endtask

    task automatic t_bad_id();
        logic ack;
        i2c_start();
        send_byte({7'h22, 1'b0}, ack);
        chk("R1 foreign address not acked", ack, 0);
        send_byte(8'h00, ack);
        chk("R1 silent after foreign address", ack, 0);
        i2c_stop();
    endtask

    task automatic t_mem_basic();
        logic ack;
        logic [7:0] d;
        mem_open_wr(16'h0010, "R2");
        send_byte(8'hA1, ack); chk("R2 data ack 0", ack, 1);
        send_byte(8'hB2, ack); chk("R3 data ack 1", ack, 1);
        send_byte(8'hC3, ack); chk("R3 data ack 2", ack, 1);
        i2c_stop();
        mem_open_rd(16'h0010, "R3");
        recv_byte(1'b1, d); chk("R2 read 0x10", d, 8'hA1);
        recv_byte(1'b1, d); chk("R3 seq read 0x11", d, 8'hB2);
        recv_byte(1'b0, d); chk("R3 seq read 0x12", d, 8'hC3);
        i2c_stop();
        mem_rd1(16'h0210, d);
        chk("R2 upper address bits ignored", d, 8'hA1);
    endtask

    task automatic t_wrap();
        logic ack;
        logic [7:0] d;
        mem_open_wr(16'h01FF, "R3");
        send_byte(8'h5A, ack); chk("R3 top byte ack", ack, 1);
        send_byte(8'h6B, ack); chk("R3 wrapped byte ack", ack, 1);
        i2c_stop();
        mem_rd1(16'h0000, d);
        chk("R3 write wrapped to 0", d, 8'h6B);
        mem_open_rd(16'h01FF, "R3");
        recv_byte(1'b1, d); chk("R3 read top", d, 8'h5A);
        recv_byte(1'b0, d); chk("R3 read wraps to 0", d, 8'h6B);
        i2c_stop();
    endtask

    task automatic t_ptr_keep();
        logic ack;
        logic [7:0] d;
        mem_rd1(16'h0011, d);
        chk("R2 read 0x11", d, 8'hB2);
        reg_wr1(8'd3, 8'h77);
        reg_rd1(8'd3, d);
        chk("R8 reg 3 readback", d, 8'h77);
        i2c_start();
        send_byte({MEM_ID, 1'b1}, ack);
        chk("R4 current read dev ack", ack, 1);
        recv_byte(1'b0, d);
        i2c_stop();
        chk("R4 pointer kept across register access", d, 8'hC3);
    endtask

    task automatic t_regs();
        logic ack;
        logic [7:0] d;
        i2c_start();
        send_byte({REG_ID, 1'b0}, ack);
        send_byte(8'd19, ack);
        send_byte(8'h44, ack); chk("R8 reg 19 ack", ack, 1);
        send_byte(8'h55, ack); chk("R8 reg 20 ack", ack, 1);
        send_byte(8'h66, ack); chk("R9 reg 21 write still acked", ack, 1);
        i2c_stop();
        i2c_start();
        send_byte({REG_ID, 1'b0}, ack);
        send_byte(8'd19, ack);
        i2c_start();
        send_byte({REG_ID, 1'b1}, ack);
        recv_byte(1'b1, d); chk("R8 reg 19 read", d, 8'h44);
        recv_byte(1'b1, d); chk("R8 reg 20 read", d, 8'h55);
        recv_byte(1'b0, d); chk("R9 reg 21 reads zero", d, 8'h00);
        i2c_stop();
        reg_rd1(8'd30, d);
        chk("R9 reg 30 reads zero", d, 8'h00);
    endtask

    task automatic t_protect();
        logic ack;
        logic [7:0] d;
        mem_wr1(16'h0000, 8'h10, ack); chk("R5 write 0x000 open", ack, 1);
        mem_wr1(16'h007F, 8'h11, ack); chk("R5 write 0x07F open", ack, 1);
        mem_wr1(16'h00FF, 8'h13, ack); chk("R5 write 0x0FF open", ack, 1);
        mem_wr1(16'h01FF, 8'h15, ack); chk("R5 write 0x1FF open", ack, 1);
        reg_wr1(8'd11, 8'h01);
        mem_wr1(16'h0000, 8'hE0, ack); chk("R6 quarter: 0x000 not acked", ack, 0);
        mem_rd1(16'h0000, d);          chk("R6 quarter: 0x000 unchanged", d, 8'h10);
        mem_wr1(16'h007F, 8'hE1, ack); chk("R6 quarter: 0x07F not acked", ack, 0);
        mem_rd1(16'h007F, d);          chk("R6 quarter: 0x07F unchanged", d, 8'h11);
        mem_wr1(16'h0080, 8'hE2, ack); chk("R6 quarter: 0x080 acked", ack, 1);
        mem_rd1(16'h0080, d);          chk("R6 quarter: 0x080 written", d, 8'hE2);
        reg_wr1(8'd11, 8'h02);
        mem_wr1(16'h00FF, 8'hE3, ack); chk("R7 half: 0x0FF not acked", ack, 0);
        mem_rd1(16'h00FF, d);          chk("R7 half: 0x0FF unchanged", d, 8'h13);
        mem_wr1(16'h0100, 8'hE4, ack); chk("R7 half: 0x100 acked", ack, 1);
        mem_rd1(16'h0100, d);          chk("R7 half: 0x100 written", d, 8'hE4);
        reg_wr1(8'd11, 8'h03);
        mem_wr1(16'h01FF, 8'hE5, ack); chk("R7 full: 0x1FF not acked", ack, 0);
        mem_rd1(16'h01FF, d);          chk("R7 full: 0x1FF unchanged", d, 8'h15);
        reg_wr1(8'd11, 8'h00);
        mem_wr1(16'h0000, 8'hE9, ack); chk("R5 cleared: 0x000 acked", ack, 1);
        mem_rd1(16'h0000, d);          chk("R5 cleared: 0x000 written", d, 8'hE9);
    endtask

    task automatic t_abort();
        logic ack;
        logic [7:0] d;
        mem_wr1(16'h0020, 8'h31, ack);
        mem_open_wr(16'h0020, "R10");
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        i2c_stop();
        mem_rd1(16'h0020, d);
        chk("R10 STOP mid-byte leaves memory", d, 8'h31);
        i2c_stop();
        send_byte({MEM_ID, 1'b0}, ack);
        chk("R10 no ack without START", ack, 0);
        i2c_start();
        send_byte({MEM_ID, 1'b0}, ack);
        send_byte(8'h00, ack);
        i2c_start();
        send_byte({MEM_ID, 1'b0}, ack); chk("R10 repeated START re-addresses", ack, 1);
        send_byte(8'h00, ack);
        send_byte(8'h20, ack);
        send_byte(8'h42, ack);          chk("R10 write after restart acked", ack, 1);
        i2c_stop();
        mem_rd1(16'h0020, d);
        chk("R10 write after restart stored", d, 8'h42);
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_bad_id();
        t_mem_basic();
        t_wrap();
        t_ptr_keep();
        t_regs();
        t_protect();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule